// File: doc/BRIEF.md
# Multi-Mode Event Timer Channel

This block is a single 24-bit up-counting timer channel for a larger peripheral. Software programs it through a small write port with four registers: a control word, a load value, a compare value and a status word whose flag bits clear when written with a one. Each cycle the channel advances on a one-cycle event pulse. That pulse may come from a divided internal clock or from an external event.

The mode field chooses how the counter gets its start value and when it restarts. In timer and watchdog modes, the counter picks up the load value on the first event after enable. With reload on, it restarts from that value whenever an event finds it at the compare value. In PWM mode it restarts on every overflow and drives an output level that shows which part of the period it is in. In the two measurement modes, a qualifying edge on a separate sense input restarts the counter. The channel keeps two sticky flags: one for compare match and one for overflow.

Top module: `modal_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0, the PWM output is 0 and all registers hold 0. The channel is disabled, in mode 0, with reload off.
- R2: While the enable bit (control bit 0) is 0, the count holds and events are ignored. In timer, watchdog and PWM modes, the first event after enable loads the load value instead of counting. Clearing enable re-arms this wait.
- R3: Once the channel is counting, each event adds one to the count. A cycle without an event leaves the count unchanged.
- R4: In timer modes 0 to 3 and watchdog modes 9 and 10, with the reload bit (control bit 5) set, an event that finds the count equal to the compare value loads the load value.
- R5: With the reload bit clear, the counter never reloads. It moves past the compare value and wraps from all ones to zero.
- R6: An event that finds the count at all ones sets the sticky overflow flag on that edge. Writing status bit 1 as one clears it, but a new overflow in the same cycle wins.
- R7: An event that finds the count equal to the compare value sets the sticky compare flag on that edge. Writing status bit 0 as one clears it, but a new match in the same cycle wins.
- R8: In mode 7 with reload set, an overflow loads the load value. The PWM output goes high on the first-event preload and on every overflow. It goes low on a compare match. It is 0 whenever the channel is disabled or not in mode 7.
- R9: In mode 4 (rising edge of the sense input) and mode 5 (falling edge), the count advances on events from the moment of enable, with no first-event preload. With reload set, a qualifying edge loads the load value and takes precedence over an event in the same cycle. The other edge has no effect.
- R10: Modes 6, 8 and 11 to 15 are unsupported. In these modes the count holds and neither flag is set.
- R11: The write port uses these addresses: 0 is control (bit 0 enable, bits 4:1 mode, bit 5 reload), 1 is load, 2 is compare, 3 is the status clear. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 24 | Write data |
| tick_i | input | 1 | One-cycle count event |
| meas_i | input | 1 | Sense input for the measurement modes |
| count_o | output | 24 | Current count |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| pwm_o | output | 1 | PWM output level |

## Verification
The bench first checks that events before enable are ignored and that the first event after enable loads rather than increments. A design that counted straight away would show an off-by-one start value. It then runs the count into the compare value with reload on and then off. A wrong reload choice either restarts when it should run free or runs past the compare value. In PWM mode it follows a full period and checks that the count comes back to the load value, not zero, on overflow, and that the output falls at the match. It applies rising and falling sense edges in both measurement modes, where using the wrong edge polarity would load at the wrong moment. It also checks that unsupported modes leave the count frozen.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;

    localparam int MODE_W = 4;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_LOAD = 2'd1,
        A_CMP  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        MC_NONE,
        MC_TIMER,
        MC_WDOG,
        MC_PWM,
        MC_MEAS_RISE,
        MC_MEAS_FALL
    } mode_class_e;

    // packed so that bit 0 is enable, bits 4:1 mode, bit 5 reload
    typedef struct packed {
        logic              trm;
        logic [MODE_W-1:0] mode;
        logic              en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic mode_class_e classify(input logic [MODE_W-1:0] m);
        mode_class_e c;
        case (m)
            4'd0, 4'd1, 4'd2, 4'd3: c = MC_TIMER;
            4'd4:                   c = MC_MEAS_RISE;
            4'd5:                   c = MC_MEAS_FALL;
            4'd7:                   c = MC_PWM;
            4'd9, 4'd10:            c = MC_WDOG;
            default:                c = MC_NONE;
        endcase
        return c;
    endfunction

    function automatic logic is_meas(input mode_class_e c);
        return (c == MC_MEAS_RISE) || (c == MC_MEAS_FALL);
    endfunction

endpackage

// File: rtl/modal_timer_regs.sv
module modal_timer_regs
    import modal_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              clr_cmp_o,
    output logic              clr_ovf_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  cmp;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        clr_cmp_o = 1'b0;
        clr_ovf_o = 1'b0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CTRL: st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                A_LOAD: st_d.load = wr_data;
                A_CMP:  st_d.cmp  = wr_data;
                A_STAT: begin
                    clr_cmp_o = wr_data[0];
                    clr_ovf_o = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign load_o = st_q.load;
    assign cmp_o  = st_q.cmp;

endmodule

// File: rtl/modal_timer_edge.sv
module modal_timer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i  & ~prev_q;
        fall_o = ~sig_i &  prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/modal_timer_cnt.sv
module modal_timer_cnt
    import modal_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             clr_cmp_i,
    input  logic             clr_ovf_i,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_flag_o,
    output logic             ovf_flag_o,
    output logic             pwm_o,
    output logic             primed_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             primed;
        logic             cflag;
        logic             oflag;
        logic             pwm;
    } cnt_state_t;

    cnt_state_t  st_d, st_q;
    mode_class_e cls;
    logic        meas, active, run, hit, wrap, qual, edge_ld, first, restart;

    always_comb begin
        cls     = classify(ctrl_i.mode);
        meas    = is_meas(cls);
        active  = ctrl_i.en && (cls != MC_NONE);
        run     = active && (meas || st_q.primed);
        hit     = run && tick_i && (st_q.count == cmp_i);
        wrap    = run && tick_i && (st_q.count == ALL_ONES);
        qual    = ((cls == MC_MEAS_RISE) && rise_i) || ((cls == MC_MEAS_FALL) && fall_i);
        edge_ld = active && ctrl_i.trm && qual;
        first   = active && !meas && !st_q.primed && tick_i;
        restart = ctrl_i.trm &&
                  ((((cls == MC_TIMER) || (cls == MC_WDOG)) && hit) ||
                   ((cls == MC_PWM) && wrap));

        st_d = st_q;
        if (active) begin
            if (edge_ld || first)   st_d.count = load_i;
            else if (run && tick_i) st_d.count = restart ? load_i : st_q.count + 1'b1;
        end
        st_d.primed = active && !meas && (st_q.primed || tick_i);
        st_d.cflag  = (st_q.cflag & ~clr_cmp_i) | hit;
        st_d.oflag  = (st_q.oflag & ~clr_ovf_i) | wrap;

        if (!(active && (cls == MC_PWM))) st_d.pwm = 1'b0;
        else if (first || wrap)           st_d.pwm = 1'b1;
        else if (hit)                     st_d.pwm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o    = st_q.count;
    assign cmp_flag_o = st_q.cflag;
    assign ovf_flag_o = st_q.oflag;
    assign pwm_o      = st_q.pwm;
    assign primed_o   = st_q.primed;

endmodule

// File: rtl/modal_timer.sv
module modal_timer
    import modal_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick_i,
    input  logic              meas_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              cmp_flag_o,
    output logic              ovf_flag_o,
    output logic              pwm_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cmp_val;
    logic             clr_cmp, clr_ovf;
    logic             rise, fall, primed;

    modal_timer_regs #(.CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl_o    (ctrl),
        .load_o    (load_val),
        .cmp_o     (cmp_val),
        .clr_cmp_o (clr_cmp),
        .clr_ovf_o (clr_ovf)
    );

    modal_timer_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (meas_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    modal_timer_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .load_i     (load_val),
        .cmp_i      (cmp_val),
        .tick_i     (tick_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .clr_cmp_i  (clr_cmp),
        .clr_ovf_i  (clr_ovf),
        .count_o    (count_o),
        .cmp_flag_o (cmp_flag_o),
        .ovf_flag_o (ovf_flag_o),
        .pwm_o      (pwm_o),
        .primed_o   (primed)
    );

endmodule

// File: rtl/modal_timer_sva.sv
module modal_timer_sva
    import modal_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cmp_val,
    input logic             clr_cmp,
    input logic             clr_ovf,
    input logic             primed,
    input logic             tick_i,
    input logic [CNT_W-1:0] count_o,
    input logic             cmp_flag_o,
    input logic             ovf_flag_o,
    input logic             pwm_o
);

    mode_class_e cls;
    logic        counting_cls, timer_cls, run;

    always_comb begin
        cls          = classify(ctrl.mode);
        counting_cls = (cls == MC_TIMER) || (cls == MC_WDOG) || (cls == MC_PWM);
        timer_cls    = (cls == MC_TIMER) || (cls == MC_WDOG);
        run          = ctrl.en && (cls != MC_NONE) && (is_meas(cls) || primed);
    end

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> $stable(count_o)); // R2

    AST_FIRST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && counting_cls && !primed && tick_i) |=> (count_o == $past(load_val))); // R2

    AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && timer_cls && ctrl.trm && primed && tick_i && count_o == cmp_val)
        |=> (count_o == $past(load_val))); // R4

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_i && count_o == {CNT_W{1'b1}}) |=> ovf_flag_o); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !clr_ovf) |=> ovf_flag_o); // R6

    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag_o && !clr_cmp) |=> cmp_flag_o); // R7

    AST_PWM_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.en && cls == MC_PWM) |=> !pwm_o); // R8

    AST_UNSUPPORTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && cls == MC_NONE) |=> $stable(count_o)); // R10

endmodule

bind modal_timer modal_timer_sva #(.CNT_W(CNT_W)) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .load_val   (load_val),
    .cmp_val    (cmp_val),
    .clr_cmp    (clr_cmp),
    .clr_ovf    (clr_ovf),
    .primed     (primed),
    .tick_i     (tick_i),
    .count_o    (count_o),
    .cmp_flag_o (cmp_flag_o),
    .ovf_flag_o (ovf_flag_o),
    .pwm_o      (pwm_o)
);

// File: tb/modal_timer_tb.sv
module modal_timer_tb_top;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         tick_i = 1'b0;
    logic         meas_i = 1'b0;
    logic [W-1:0] count_o;
    logic         cmp_flag_o, ovf_flag_o, pwm_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    modal_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_i(tick_i), .meas_i(meas_i),
        .count_o(count_o), .cmp_flag_o(cmp_flag_o),
        .ovf_flag_o(ovf_flag_o), .pwm_o(pwm_o)
    );

    // behavioural reference model
    bit           m_en, m_trm, m_primed, m_cf, m_of, m_pwm, m_prev;
    int           m_mode;
    logic [W-1:0] m_cnt, m_load, m_cmp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_trm = 0; m_mode = 0; m_primed = 0; m_cf = 0; m_of = 0;
            m_pwm = 0; m_prev = 0; m_cnt = '0; m_load = '0; m_cmp = '0;
        end else begin
            bit tw, pwmm, meas, sup, go, hit, wrap, edge_hit, first, clrc, clro;
            tw   = (m_mode <= 3) || m_mode == 9 || m_mode == 10;
            pwmm = (m_mode == 7);
            meas = (m_mode == 4) || (m_mode == 5);
            sup  = tw || pwmm || meas;
            go   = m_en && sup && (meas || m_primed);
            hit  = go && tick_i && (m_cnt == m_cmp);
            wrap = go && tick_i && (m_cnt == {W{1'b1}});
            edge_hit = m_en && m_trm &&
                       ((m_mode == 4 && meas_i && !m_prev) || (m_mode == 5 && !meas_i && m_prev));
            first = m_en && sup && !meas && !m_primed && tick_i;
            clrc = wr_en && wr_addr == 2'd3 && wr_data[0];
            clro = wr_en && wr_addr == 2'd3 && wr_data[1];
            if (m_en && sup) begin
                if (edge_hit || first) m_cnt = m_load;
                else if (go && tick_i) begin
                    if (m_trm && ((tw && hit) || (pwmm && wrap))) m_cnt = m_load;
                    else m_cnt = m_cnt + 1'b1;
                end
            end
            if (!(m_en && pwmm))    m_pwm = 0;
            else if (first || wrap) m_pwm = 1;
            else if (hit)           m_pwm = 0;
            m_primed = m_en && sup && !meas && (m_primed || tick_i);
            m_cf = (m_cf && !clrc) || hit;
            m_of = (m_of && !clro) || wrap;
            m_prev = meas_i;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_en = wr_data[0]; m_mode = int'(wr_data[4:1]); m_trm = wr_data[5]; end
                    2'd1: m_load = wr_data;
                    2'd2: m_cmp = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (count_o !== m_cnt || cmp_flag_o !== m_cf || ovf_flag_o !== m_of || pwm_o !== m_pwm) begin
                errors++;
                $display("FAIL model %s: act cnt=%h cf=%b of=%b pwm=%b exp cnt=%h cf=%b of=%b pwm=%b",
                         cur_req, count_o, cmp_flag_o, ovf_flag_o, pwm_o, m_cnt, m_cf, m_of, m_pwm);
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: act hung exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic chk_cnt(input string req, input logic [W-1:0] exp);
        chk(count_o === exp, req, count_o, exp);
    endtask

    task automatic cyc(input bit t, input bit m);
        tick_i = t; meas_i = m;
        @(negedge clk); #2;
        tick_i = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk_cnt("R1", '0);
        chk(!cmp_flag_o && !ovf_flag_o && !pwm_o, "R1", {21'd0, cmp_flag_o, ovf_flag_o, pwm_o}, '0);

        // R11 register map; R2 first-event preload
        cur_req = "R2";
        wr(2'd1, 24'd100);
        cyc(1, 0);                         // disabled: event ignored
        chk_cnt("R2", '0);
        wr(2'd2, 24'd103);
        wr(2'd0, 24'h21);                  // en, mode 0, reload
        cyc(0, 0); cyc(0, 0);
        chk_cnt("R2", '0);
        cyc(1, 0);
        chk_cnt("R2", 24'd100);

        // R3 counting, R4 match reload, R7 compare flag
        cur_req = "R3";
        for (int i = 0; i < 3; i++) cyc(1, 0);
        chk_cnt("R3", 24'd103);
        cyc(0, 0);
        chk_cnt("R3", 24'd103);
        cur_req = "R4";
        cyc(1, 0);
        chk_cnt("R4", 24'd100);
        chk(cmp_flag_o === 1'b1, "R7", W'(cmp_flag_o), 24'd1);
        wr(2'd3, 24'd1);
        chk(cmp_flag_o === 1'b0, "R7", W'(cmp_flag_o), 24'd0);

        // R5 free run past compare
        cur_req = "R5";
        wr(2'd0, 24'h01);
        for (int i = 0; i < 4; i++) cyc(1, 0);
        chk_cnt("R5", 24'd104);
        chk(cmp_flag_o === 1'b1, "R7", W'(cmp_flag_o), 24'd1);

        // R2 disable holds, re-enable re-arms
        cur_req = "R2";
        wr(2'd0, 24'h00);
        cyc(1, 0); cyc(1, 0);
        chk_cnt("R2", 24'd104);
        wr(2'd0, 24'h21);
        cyc(1, 0);
        chk_cnt("R2", 24'd100);

        // R6 overflow in watchdog mode, reload off
        cur_req = "R6";
        wr(2'd0, 24'h00);
        wr(2'd3, 24'd3);
        wr(2'd1, 24'hFFFFFD);
        wr(2'd2, 24'd5);
        wr(2'd0, 24'h13);
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        chk_cnt("R6", 24'hFFFFFF);
        cyc(1, 0);
        chk_cnt("R6", 24'd0);
        chk(ovf_flag_o === 1'b1, "R6", W'(ovf_flag_o), 24'd1);
        wr(2'd3, 24'd2);
        chk(ovf_flag_o === 1'b0, "R6", W'(ovf_flag_o), 24'd0);

        // R8 PWM period
        cur_req = "R8";
        wr(2'd0, 24'h00);
        wr(2'd1, 24'hFFFFF0);
        wr(2'd2, 24'hFFFFF4);
        wr(2'd0, 24'h2F);
        cyc(1, 0);
        chk_cnt("R8", 24'hFFFFF0);
        chk(pwm_o === 1'b1, "R8", W'(pwm_o), 24'd1);
        for (int i = 0; i < 4; i++) cyc(1, 0);
        chk(pwm_o === 1'b1, "R8", W'(pwm_o), 24'd1);
        cyc(1, 0);
        chk(pwm_o === 1'b0, "R8", W'(pwm_o), 24'd0);
        for (int i = 0; i < 10; i++) cyc(1, 0);
        chk_cnt("R8", 24'hFFFFFF);
        cyc(1, 0);
        chk_cnt("R8", 24'hFFFFF0);
        chk(pwm_o === 1'b1 && ovf_flag_o === 1'b1, "R8", {22'd0, pwm_o, ovf_flag_o}, 24'd3);

        // R9 measurement modes
        cur_req = "R9";
        wr(2'd0, 24'h00);
        wr(2'd1, 24'd50);
        wr(2'd0, 24'h29);                  // mode 4, reload, en
        held = count_o;
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        chk_cnt("R9", held + 24'd3);
        cyc(0, 1);                         // rising edge
        chk_cnt("R9", 24'd50);
        cyc(1, 1);
        chk_cnt("R9", 24'd51);
        wr(2'd0, 24'h2B);                  // mode 5
        cyc(1, 0);                         // falling edge beats the event
        chk_cnt("R9", 24'd50);
        cyc(0, 1);                         // rising edge ignored
        chk_cnt("R9", 24'd50);
        chk(pwm_o === 1'b0, "R8", W'(pwm_o), 24'd0);

        // R10 unsupported mode
        cur_req = "R10";
        wr(2'd3, 24'd3);
        wr(2'd0, 24'h0D);                  // mode 6
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        chk_cnt("R10", 24'd50);
        chk(!cmp_flag_o && !ovf_flag_o, "R10", {22'd0, cmp_flag_o, ovf_flag_o}, 24'd0);

        cyc(0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule